// File: doc/BRIEF.md
# I2C Register Slave with Auto-Increment

This block is a two-wire serial slave that gives an external controller read and write access to a bank of 8-bit registers. The system clock oversamples SCL and SDA. The block finds START, repeated START and STOP conditions, compares the first byte of a transfer against a fixed 7-bit device address, and pulls SDA low to acknowledge. The SDA output is open-drain and only ever pulls low.

After the address, the controller sends a pointer byte. Its low seven bits name a register, and its top bit selects whether the pointer steps forward after each data byte. A write continues with data bytes that land in the register bank through a one-cycle strobe. A read first sets the pointer with a write-direction header, then issues a repeated START with the read-direction address, and the slave returns bytes MSB first until the controller answers with a not-acknowledge. The register bank is outside this block. It is reached through an address, a write strobe with data, and a combinational read-data return.

The block responds only while the select input is high. That input is the shared chip-select line, which selects the two-wire mode when it is high.

Top module: `i2c_regslave`

## Requirements
- R1: A START (SDA falling while SCL is high) starts a new address phase from any state, including in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The device address is 1011111b, so the header byte is BEh for write and BFh for read. Only a matching header is acknowledged. After a mismatch the block leaves SDA released and performs no register write until the next START.
- R3: The pointer byte sets the register pointer from its bits 6:0. When its bit 7 is 1, the pointer steps by one after every data byte and wraps from 7Fh to 00h. When bit 7 is 0, the pointer stays fixed for the whole transfer.
- R4: Each data byte received after the pointer byte writes the register at the pointer. The write is a reg_wr_o pulse one system clock long, and the byte is acknowledged.
- R5: After a repeated START with header BFh, the block returns the register at the pointer MSB first. It continues with the next register each time the controller acknowledges.
- R6: The slave acknowledges by pulling SDA low through the ninth SCL clock, and releases it after that clock's falling edge.
- R7: After a controller not-acknowledge, the block releases SDA and drives nothing further until a START or STOP.
- R8: A START or STOP that arrives before a byte is complete discards that byte, and no register write takes place.
- R9: The block changes its SDA drive only while SCL is low.
- R10: While bus_sel_i is low, the block ignores the bus: it sends no acknowledge, drives nothing and writes nothing.
- R11: After reset, SDA is released and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | High to enable the two-wire slave (shared chip-select line) |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr_o | output | 7 | Register pointer presented to the bank |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Data for the write strobe |
| reg_rdata_i | input | 8 | Combinational read data of the register at reg_addr_o |

## Verification
The bench builds the block with its default parameters: device address 5Fh and a two-stage input synchronizer. It runs the bus at eight system clocks per quarter bit, which leaves room for the synchronizer delay before every SCL edge. The whole 7-bit pointer space can be reached, so a transfer that starts at 7Eh with stepping enabled exercises the wrap to 00h. Directed transfers add the cases that need precise bus timing: a START or STOP in the middle of a byte, a wrong address, a held not-acknowledge, and a low select line.

// File: rtl/i2c_rs_pkg.sv
`timescale 1ns/1ps
package i2c_rs_pkg;

    localparam int BYTE_W = 8;
    localparam int PTR_W  = 7;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_MACK
    } rs_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic hdr_match(input logic [BYTE_W-1:0] hdr,
                                       input logic [PTR_W-1:0] dev);
        return hdr[BYTE_W-1:1] == dev;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                  input logic step);
        return p + {{(PTR_W-1){1'b0}}, step};
    endfunction

endpackage

// File: rtl/i2c_rs_sync.sv
`timescale 1ns/1ps
module i2c_rs_sync
    import i2c_rs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p[0] <= scl_i;
            sda_p[0] <= sda_i;
            for (int i = 1; i < STAGES; i++) begin
                scl_p[i] <= scl_p[i-1];
                sda_p[i] <= sda_p[i-1];
            end
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2c_rs_engine.sv
`timescale 1ns/1ps
module i2c_rs_engine
    import i2c_rs_pkg::*;
#(
    parameter logic [PTR_W-1:0] DEV_ADDR = 7'h5F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rdata,
    output logic              sda_pull,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wdata
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rs_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic              full;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              step_en;
    logic              rd_dir;
    logic              mack;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            full     <= 1'b0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            step_en  <= 1'b0;
            rd_dir   <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            ptr      <= '0;
            wr_stb   <= 1'b0;
            wdata    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.start) begin
                state    <= ST_ADDR;
                cnt      <= '0;
                full     <= 1'b0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                cnt      <= '0;
                full     <= 1'b0;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (evt.scl_rise && !full) begin
                            rx_sh <= {rx_sh[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) full <= 1'b1;
                        end else if (evt.scl_fall && full) begin
                            full <= 1'b0;
                            cnt  <= '0;
                            if (state == ST_ADDR) begin
                                if (hdr_match(rx_sh, DEV_ADDR)) begin
                                    rd_dir   <= rx_sh[0];
                                    sda_pull <= 1'b1;
                                    state    <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_SUB) begin
                                ptr      <= rx_sh[PTR_W-1:0];
                                step_en  <= rx_sh[BYTE_W-1];
                                sda_pull <= 1'b1;
                                state    <= ST_SUB_ACK;
                            end else begin
                                wr_stb   <= 1'b1;
                                wdata    <= rx_sh;
                                sda_pull <= 1'b1;
                                state    <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (rd_dir) begin
                                tx_sh    <= rdata;
                                sda_pull <= ~rdata[BYTE_W-1];
                                ptr      <= ptr_step(ptr, step_en);
                                state    <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_SUB;
                            end
                        end
                    end
                    ST_SUB_ACK: begin
                        if (evt.scl_fall) begin
                            sda_pull <= 1'b0;
                            state    <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (evt.scl_fall) begin
                            sda_pull <= 1'b0;
                            ptr      <= ptr_step(ptr, step_en);
                            state    <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_pull <= 1'b0;
                                cnt      <= '0;
                                state    <= ST_MACK;
                            end else begin
                                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~tx_sh[BYTE_W-2];
                                cnt      <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (mack) begin
                                tx_sh    <= rdata;
                                sda_pull <= ~rdata[BYTE_W-1];
                                ptr      <= ptr_step(ptr, step_en);
                                state    <= ST_RDATA;
                            end else begin
                                sda_pull <= 1'b0;
                                state    <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regslave.sv
`timescale 1ns/1ps
module i2c_regslave
    import i2c_rs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h5F,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [6:0] reg_addr_o,
    output logic       reg_wr_o,
    output logic [7:0] reg_wdata_o,
    input  logic [7:0] reg_rdata_i
);
    bus_evt_t evt;

    i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_rs_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .clr      (~bus_sel_i),
        .evt      (evt),
        .rdata    (reg_rdata_i),
        .sda_pull (sda_pull_o),
        .ptr      (reg_addr_o),
        .wr_stb   (reg_wr_o),
        .wdata    (reg_wdata_o)
    );
endmodule

// File: rtl/i2c_regslave_chk.sv
`timescale 1ns/1ps
module i2c_regslave_chk (
    input logic clk,
    input logic rst,
    input logic sel,
    input logic scl_s,
    input logic stop_evt,
    input logic pull,
    input logic wr
);
    // R9: the drive changes only after SCL was seen low
    a_r9_drive_change_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(pull) |-> !$past(scl_s));

    // R10: deselected slave never drives
    a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !pull);

    // R4: write strobe lasts one cycle
    a_r4_write_single_pulse: assert property (@(posedge clk) disable iff (rst)
        wr |=> !wr);

    // R4: every write is acknowledged
    a_r4_write_acked: assert property (@(posedge clk) disable iff (rst)
        wr |-> pull);

    // R1: STOP releases SDA
    a_r1_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> !pull);
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (bus_sel_i),
    .scl_s    (evt.scl),
    .stop_evt (evt.stop),
    .pull     (sda_pull_o),
    .wr       (reg_wr_o)
);

// File: tb/test_i2c_regslave.sv
`timescale 1ns/1ps
module test_i2c_regslave;
    localparam int Q = 8;
    // {pointer byte, d0, d1, d2, count}
    localparam logic [33:0] VEC [6] = '{
        {8'h85, 8'h3C, 8'hA5, 8'h00, 2'd2},
        {8'h10, 8'h11, 8'h22, 8'h33, 2'd3},
        {8'hFE, 8'h7E, 8'h81, 8'hC3, 2'd3},
        {8'h40, 8'hFF, 8'h00, 8'h00, 2'd1},
        {8'hA0, 8'h01, 8'h80, 8'h55, 2'd3},
        {8'h2A, 8'h00, 8'h00, 8'h00, 2'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic [6:0] raddr;
    logic rwr;
    logic [7:0] rwdata, rrdata;
    logic [7:0] bank [128];
    logic [7:0] expb [128];
    int wr_count = 0;
    int total = 0;
    int fails = 0;
    int r9_viol = 0;
    logic scl_d = 1'b1;
    logic pull_d = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_regslave i_i2c_regslave (
        .clk         (clk),
        .rst         (rst),
        .bus_sel_i   (sel),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .reg_addr_o  (raddr),
        .reg_wr_o    (rwr),
        .reg_wdata_o (rwdata),
        .reg_rdata_i (rrdata)
    );

    assign rrdata = bank[raddr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 128; i++) bank[i] <= 8'h00;
        end else if (rwr) begin
            bank[raddr] <= rwdata;
            wr_count <= wr_count + 1;
        end
        scl_d  <= scl_m;
        pull_d <= sda_pull;
        if (!rst && (sda_pull != pull_d) && scl_m && scl_d) r9_viol <= r9_viol + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic xfer_bit(input logic b, output logic s);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait();
        s = sda_line;
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
        xfer_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            xfer_bit(1'b1, s);
            b = {b[6:0], s};
        end
        xfer_bit(~give_ack, s);
    endtask

    task automatic wr_txn(input logic [7:0] sub, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic a;
        logic [7:0] d;
        logic [6:0] p;
        p = sub[6:0];
        bus_start();
        send_byte(8'hBE, a); chk(a, "R2 write header ack", a, 1);
        send_byte(sub, a);   chk(a, "R3 pointer ack", a, 1);
        for (int k = 0; k < n; k++) begin
            d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            send_byte(d, a);
            chk(a, "R4 data ack", a, 1);
            chk(sda_pull == 1'b0, "R6 release after ack", sda_pull, 0);
            expb[p] = d;
            if (sub[7]) p = p + 7'd1;
        end
        bus_stop();
    endtask

    task automatic rd_txn(input logic [7:0] sub, input int n);
        logic a;
        logic [7:0] b;
        logic [6:0] p;
        p = sub[6:0];
        bus_start();
        send_byte(8'hBE, a); chk(a, "R2 header ack", a, 1);
        send_byte(sub, a);   chk(a, "R3 pointer ack", a, 1);
        bus_start();
        send_byte(8'hBF, a); chk(a, "R5 read header ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == expb[p], "R5 R3 read data", b, expb[p]);
            if (sub[7]) p = p + 7'd1;
        end
        chk(sda_pull == 1'b0, "R7 release after nack", sda_pull, 0);
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic a, s, held;
        logic [7:0] b;
        int w0;
        for (int i = 0; i < 128; i++) expb[i] = 8'h00;
        repeat (5) @(negedge clk);
        chk(sda_pull == 1'b0, "R11 reset drive", sda_pull, 0);
        chk(rwr == 1'b0, "R11 reset strobe", rwr, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            wr_txn(VEC[i][33:26], int'(VEC[i][1:0]), VEC[i][25:18], VEC[i][17:10], VEC[i][9:2]);
            rd_txn(VEC[i][33:26], int'(VEC[i][1:0]));
        end

        // R2: wrong address is ignored
        w0 = wr_count;
        bus_start();
        send_byte(8'hA0, a); chk(!a, "R2 foreign header nack", a, 0);
        send_byte(8'h05, a); chk(!a, "R2 stays released", a, 0);
        send_byte(8'hEE, a);
        bus_stop();
        chk(wr_count == w0, "R2 no write on mismatch", wr_count, w0);

        // R8/R1: START mid-byte aborts, new address phase follows
        w0 = wr_count;
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'h05, a);
        xfer_bit(1'b1, s); xfer_bit(1'b0, s); xfer_bit(1'b1, s); xfer_bit(1'b0, s);
        bus_start();
        chk(wr_count == w0, "R8 start mid-byte no write", wr_count, w0);
        send_byte(8'hBE, a); chk(a, "R1 restart address ack", a, 1);
        send_byte(8'h09, a);
        send_byte(8'h5A, a); chk(a, "R1 write after restart", a, 1);
        expb[9] = 8'h5A;
        bus_stop();
        chk(sda_pull == 1'b0, "R1 released after stop", sda_pull, 0);
        rd_txn(8'h05, 1);
        rd_txn(8'h09, 1);

        // R8: STOP mid-byte aborts
        w0 = wr_count;
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'h07, a);
        xfer_bit(1'b0, s); xfer_bit(1'b1, s); xfer_bit(1'b1, s);
        bus_stop();
        chk(wr_count == w0, "R8 stop mid-byte no write", wr_count, w0);
        rd_txn(8'h07, 1);

        // R7: after nack the slave keeps SDA released
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'h85, a);
        bus_start();
        send_byte(8'hBF, a);
        recv_byte(1'b0, b);
        chk(b == expb[5], "R5 single read", b, expb[5]);
        held = 1'b1;
        for (int i = 0; i < 9; i++) begin
            xfer_bit(1'b1, s);
            held = held & s;
        end
        chk(held, "R7 no drive after nack", held, 1);
        bus_stop();

        // R10: deselected
        sel = 1'b0;
        w0 = wr_count;
        bus_start();
        send_byte(8'hBE, a); chk(!a, "R10 no ack when deselected", a, 0);
        send_byte(8'h05, a);
        send_byte(8'h99, a);
        bus_stop();
        chk(wr_count == w0, "R10 no write when deselected", wr_count, w0);
        sel = 1'b1;
        repeat (4) @(negedge clk);
        rd_txn(8'h05, 1);

        chk(r9_viol == 0, "R9 drive change while SCL high", r9_viol, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule